// File: doc/BRIEF.md
# Indirect Interrupt Router Register File

This block is the software-visible configuration store of an interrupt router. Software reaches it through two 32-bit locations only. One holds a selector. The other is a data window that reaches whatever the selector names: the router's 4-bit identifier, a read-only version word, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin. Each entry carries a vector, a delivery mode, a destination mode, an input polarity, a remote-IRR status flag, a trigger mode, a mask and a destination ID.

The service logic next to this block receives every field of every entry on flat output buses. It also receives a per-pin pending vector, which is the pin level corrected by the entry's polarity. After every accepted table write, the block raises a one-cycle strobe that carries the entry index, so the service logic can look again at a request pending on that pin. The service logic sets the remote-IRR flag through a per-pin set input. Software cannot write that flag, and it is cleared whenever software rewrites the low half of the entry.

Every access is answered exactly one cycle later with a response valid flag, an error flag and read data. Read data reflects the state before the access.

Top module: `intr_route_regs`

## Requirements
- R1: Only address bits [7:0] are decoded. Offset 0x00 is the selector, which reads back the last value written. Offset 0x10 is the data window. Any other offset reads as zero and ignores writes. A selector value that names neither a register nor an entry (0x03 to 0x0F) reads as zero through the window.
- R2: Selector 0x01 reads as {8'h00, PINS-1, 8'h00, VERSION}. Writes to it change nothing.
- R3: Selectors 0x00 and 0x02 both read the identifier in bits [27:24], with all other bits zero. Only a window write at selector 0x00 loads the identifier, taken from write-data bits [27:24].
- R4: A selector S of 0x10 or above addresses entry (S-0x10)>>1. Odd S reaches entry bits [63:32] and even S reaches bits [31:0]. Writing one half leaves the other half unchanged.
- R5: A low-half write replaces bits [31:0] except bit 14, and it clears the remote-IRR flag (bit 14). Software never sets bit 14. A high-half write leaves the flag as it was.
- R6: When the entry index is PINS or more, the access touches no entry. Writes are dropped and raise no strobe, and reads return zero. Index PINS-1 still works.
- R7: A write is accepted only with a size of 4 or 8 bytes, and only write-data bits [31:0] are used. A read is accepted with sizes 1, 2, 4 or 8, and sizes 1 and 2 return only the low 1 or 2 bytes. Any other size answers with resp_err=1, data zero and no change of state.
- R8: Reset sets every entry to mask=1 with all other bits zero. It also clears the selector, the identifier, the pending vector, the strobe and the response outputs.
- R9: An accepted table write raises svc_stb for exactly the cycle after the access, with svc_idx equal to the entry index.
- R10: A pulse on rirr_set[i] sets entry i's remote-IRR flag from the next cycle. A low-half write to the same entry in the same cycle wins, and the flag ends up cleared.
- R11: Field outputs for pin i come from entry i. Vector is bits [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote IRR [14], level trigger [15] (1 = level), mask [16] and destination [63:56].
- R12: pend[i] is registered and equals pin_lvl[i] XOR the polarity of entry i, one cycle after the inputs.
- R13: resp_valid is high in the cycle after each acc_valid and in no other cycle. Write responses carry data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; bits [7:0] decoded |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 64 | Write data; bits [31:0] used |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_err | output | 1 | Access size rejected |
| resp_data | output | 32 | Read data |
| rirr_set | input | PINS | Per-pin remote-IRR set pulse from service logic |
| pin_lvl | input | PINS | Raw interrupt pin levels |
| pend | output | PINS | Polarity-corrected pending vector |
| svc_stb | output | 1 | One-cycle pulse after a table write |
| svc_idx | output | IDX_W | Entry index of the table write |
| ent_vector | output | PINS*8 | Per-pin vector field |
| ent_dlv_mode | output | PINS*3 | Per-pin delivery mode |
| ent_dst_mode | output | PINS | Per-pin destination mode |
| ent_polarity | output | PINS | Per-pin polarity |
| ent_rirr | output | PINS | Per-pin remote-IRR flag |
| ent_level | output | PINS | Per-pin trigger mode, 1 = level |
| ent_mask | output | PINS | Per-pin mask |
| ent_dest | output | PINS*8 | Per-pin destination ID |

## Verification
Some behaviours are checked by assertions on every cycle. These are the one-to-one pairing of accesses and responses, and the rule that the strobe only follows a write and always names an index below PINS. They also cover the rule that a write of a rejected size raises no strobe, that the identifier and an entry's configuration hold steady without a matching write, and that the remote-IRR flag obeys its clear and set rules. Other behaviours can only be shown by the bench's scenarios. These are the actual values read through the window: the version word, the identifier alias at selector 0x02, the half selection and the narrow reads. The bench scenarios also cover the index boundary at PINS-1 against PINS, the reset contents of the table and the placement of each field on the output buses.

// File: rtl/irr_pkg.sv
package irr_pkg;

   // selector codes and window offsets
   localparam logic [7:0]  OFS_SEL      = 8'h00;
   localparam logic [7:0]  OFS_WIN      = 8'h10;
   localparam logic [31:0] SEL_ID       = 32'h0;
   localparam logic [31:0] SEL_VER      = 32'h1;
   localparam logic [31:0] SEL_ARB      = 32'h2;
   localparam logic [31:0] SEL_TBL_BASE = 32'h10;

   // routing entry field positions
   localparam int F_VEC   = 0;
   localparam int F_DLV   = 8;
   localparam int F_DSTM  = 11;
   localparam int F_POL   = 13;
   localparam int F_RIRR  = 14;
   localparam int F_LEVEL = 15;
   localparam int F_MASK  = 16;
   localparam int F_DEST  = 56;

   typedef enum logic [2:0] {
      RD_ZERO,
      RD_SEL,
      RD_VER,
      RD_ID,
      RD_TBL
   } rd_kind_e;

endpackage

// File: rtl/irr_decode.sv
module irr_decode
   import irr_pkg::*;
#(
   parameter int PINS   = 24,
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 5
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [3:0]        acc_size,
   input  logic [31:0]       sel_q,
   output logic              size_ok,
   output logic              wr_sel,
   output logic              wr_id,
   output logic              wr_tbl,
   output logic              hi_half,
   output logic              tbl_hit,
   output logic [IDX_W-1:0]  tbl_idx,
   output rd_kind_e          rd_kind
);

   logic [7:0]  ofs;
   logic [31:0] rel;
   logic [30:0] full_idx;
   logic        wr_ok;
   logic        at_sel;
   logic        at_win;
   logic        unused_rel_lsb;

   assign ofs            = acc_addr[7:0];
   assign rel            = sel_q - SEL_TBL_BASE;
   assign full_idx       = rel[31:1];
   assign unused_rel_lsb = rel[0];

   generate
      if (ADDR_W > 8) begin : g_wide_addr
         logic unused_hi_addr;
         assign unused_hi_addr = ^acc_addr[ADDR_W-1:8];
      end
   endgenerate

   assign tbl_hit = (sel_q >= SEL_TBL_BASE) && (full_idx < 31'(PINS));
   assign tbl_idx = full_idx[IDX_W-1:0];
   assign hi_half = sel_q[0];

   always_comb begin
      if (acc_write)
         size_ok = (acc_size == 4'd4) || (acc_size == 4'd8);
      else
         size_ok = (acc_size == 4'd1) || (acc_size == 4'd2) ||
                   (acc_size == 4'd4) || (acc_size == 4'd8);
   end

   assign at_sel = (ofs == OFS_SEL);
   assign at_win = (ofs == OFS_WIN);
   assign wr_ok  = acc_valid && acc_write && size_ok;
   assign wr_sel = wr_ok && at_sel;
   assign wr_id  = wr_ok && at_win && (sel_q == SEL_ID);
   assign wr_tbl = wr_ok && at_win && tbl_hit;

   always_comb begin
      rd_kind = RD_ZERO;
      if (at_sel)
         rd_kind = RD_SEL;
      else if (at_win) begin
         if (sel_q == SEL_ID || sel_q == SEL_ARB)
            rd_kind = RD_ID;
         else if (sel_q == SEL_VER)
            rd_kind = RD_VER;
         else if (tbl_hit)
            rd_kind = RD_TBL;
      end
   end

endmodule

// File: rtl/irr_entry.sv
module irr_entry
   import irr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   input  logic        rirr_set,
   output logic [63:0] ent
);

   // bits [31:15] and [13:0] of the low half are stored apart from the flag
   localparam logic [31:15] LO_UP_RST = 17'(1 << (F_MASK - 15));

   logic [31:0]  hi_q;
   logic [31:15] lo_up_q;
   logic [13:0]  lo_dn_q;
   logic         rirr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q    <= '0;
         lo_up_q <= LO_UP_RST;
         lo_dn_q <= '0;
      end else begin
         if (wr_hi)
            hi_q <= wdata;
         if (wr_lo) begin
            lo_up_q <= wdata[31:15];
            lo_dn_q <= wdata[13:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rirr_q <= 1'b0;
      else if (wr_lo)
         rirr_q <= 1'b0;
      else if (rirr_set)
         rirr_q <= 1'b1;
   end

   assign ent = {hi_q, lo_up_q[31:16], lo_up_q[15], rirr_q, lo_dn_q};

   AST_RIRR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !ent[F_RIRR]);                                      // R5
   AST_RIRR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rirr_set && !wr_lo) |=> ent[F_RIRR]);                        // R10
   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> $stable(ent[63:32]));                              // R4
   AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lo |=> ($stable(ent[31:15]) && $stable(ent[13:0])));      // R4

endmodule

// File: rtl/irr_rdmux.sv
module irr_rdmux
   import irr_pkg::*;
#(
   parameter int          PINS         = 24,
   parameter logic [7:0]  VERSION      = 8'h11,
   parameter bit          NARROW_READS = 1'b1
) (
   input  rd_kind_e    rd_kind,
   input  logic [31:0] sel_q,
   input  logic [3:0]  id_q,
   input  logic [31:0] tbl_word,
   input  logic [3:0]  acc_size,
   output logic [31:0] rdata
);

   localparam logic [7:0] LAST_PIN = 8'(PINS - 1);

   logic [31:0] raw;

   always_comb begin
      case (rd_kind)
         RD_SEL:  raw = sel_q;
         RD_VER:  raw = {8'h00, LAST_PIN, 8'h00, VERSION};
         RD_ID:   raw = {4'h0, id_q, 24'h0};
         RD_TBL:  raw = tbl_word;
         default: raw = '0;
      endcase
   end

   generate
      if (NARROW_READS) begin : g_narrow
         always_comb begin
            case (acc_size)
               4'd1:    rdata = {24'h0, raw[7:0]};
               4'd2:    rdata = {16'h0, raw[15:0]};
               default: rdata = raw;
            endcase
         end
      end else begin : g_full
         logic unused_size;
         assign unused_size = ^acc_size;
         assign rdata       = raw;
      end
   endgenerate

endmodule

// File: rtl/intr_route_regs.sv
module intr_route_regs
   import irr_pkg::*;
#(
   parameter int         PINS         = 24,
   parameter int         ADDR_W       = 12,
   parameter logic [7:0] VERSION      = 8'h11,
   parameter bit         NARROW_READS = 1'b1,
   localparam int        IDX_W        = $clog2(PINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [3:0]        acc_size,
   input  logic [63:0]       acc_wdata,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [31:0]       resp_data,
   input  logic [PINS-1:0]   rirr_set,
   input  logic [PINS-1:0]   pin_lvl,
   output logic [PINS-1:0]   pend,
   output logic              svc_stb,
   output logic [IDX_W-1:0]  svc_idx,
   output logic [PINS*8-1:0] ent_vector,
   output logic [PINS*3-1:0] ent_dlv_mode,
   output logic [PINS-1:0]   ent_dst_mode,
   output logic [PINS-1:0]   ent_polarity,
   output logic [PINS-1:0]   ent_rirr,
   output logic [PINS-1:0]   ent_level,
   output logic [PINS-1:0]   ent_mask,
   output logic [PINS*8-1:0] ent_dest
);

   // elaboration-time parameter checks
   generate
      if (PINS < 2 || PINS > 256) begin : g_bad_pins
         $error("intr_route_regs: PINS must lie in 2..256");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("intr_route_regs: ADDR_W must be at least 8");
      end
   endgenerate

   logic [31:0]      sel_q;
   logic [3:0]       id_q;
   logic [PINS-1:0]  pend_q;
   logic [63:0]      ent_arr [PINS];
   logic [31:0]      wdata;
   logic             unused_wdata_hi;

   logic             size_ok;
   logic             wr_sel;
   logic             wr_id;
   logic             wr_tbl;
   logic             hi_half;
   logic             tbl_hit;
   logic [IDX_W-1:0] tbl_idx;
   rd_kind_e         rd_kind;
   logic [31:0]      tbl_word;
   logic [31:0]      rdata;

   assign wdata           = acc_wdata[31:0];
   assign unused_wdata_hi = ^acc_wdata[63:32];

   irr_decode #(
      .PINS   (PINS),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_decode (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .sel_q     (sel_q),
      .size_ok   (size_ok),
      .wr_sel    (wr_sel),
      .wr_id     (wr_id),
      .wr_tbl    (wr_tbl),
      .hi_half   (hi_half),
      .tbl_hit   (tbl_hit),
      .tbl_idx   (tbl_idx),
      .rd_kind   (rd_kind)
   );

   // selector and identifier
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (wr_sel)
            sel_q <= wdata;
         if (wr_id)
            id_q <= wdata[27:24];
      end
   end

   // routing entries, one per pin
   generate
      for (genvar gi = 0; gi < PINS; gi++) begin : g_pin
         logic hit_i;
         assign hit_i = wr_tbl && (tbl_idx == IDX_W'(gi));

         irr_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit_i && !hi_half),
            .wr_hi    (hit_i && hi_half),
            .wdata    (wdata),
            .rirr_set (rirr_set[gi]),
            .ent      (ent_arr[gi])
         );

         assign ent_vector[gi*8 +: 8]   = ent_arr[gi][F_VEC +: 8];
         assign ent_dlv_mode[gi*3 +: 3] = ent_arr[gi][F_DLV +: 3];
         assign ent_dst_mode[gi]        = ent_arr[gi][F_DSTM];
         assign ent_polarity[gi]        = ent_arr[gi][F_POL];
         assign ent_rirr[gi]            = ent_arr[gi][F_RIRR];
         assign ent_level[gi]           = ent_arr[gi][F_LEVEL];
         assign ent_mask[gi]            = ent_arr[gi][F_MASK];
         assign ent_dest[gi*8 +: 8]     = ent_arr[gi][F_DEST +: 8];

         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_q[gi] <= 1'b0;
            else
               pend_q[gi] <= pin_lvl[gi] ^ ent_arr[gi][F_POL];
         end
      end
   endgenerate

   assign pend = pend_q;

   // window read path
   always_comb begin
      tbl_word = '0;
      if (tbl_hit)
         tbl_word = hi_half ? ent_arr[tbl_idx][63:32] : ent_arr[tbl_idx][31:0];
   end

   irr_rdmux #(
      .PINS         (PINS),
      .VERSION      (VERSION),
      .NARROW_READS (NARROW_READS)
   ) u_rdmux (
      .rd_kind  (rd_kind),
      .sel_q    (sel_q),
      .id_q     (id_q),
      .tbl_word (tbl_word),
      .acc_size (acc_size),
      .rdata    (rdata)
   );

   // response and service strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_data  <= '0;
         svc_stb    <= 1'b0;
         svc_idx    <= '0;
      end else begin
         resp_valid <= acc_valid;
         resp_err   <= acc_valid && !size_ok;
         resp_data  <= (acc_valid && !acc_write && size_ok) ? rdata : '0;
         svc_stb    <= wr_tbl;
         if (wr_tbl)
            svc_idx <= tbl_idx;
      end
   end

   AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> resp_valid);                                    // R13
   AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !resp_valid);                                  // R13
   AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_stb |-> $past(acc_valid && acc_write));                   // R9
   AST_STB_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_stb |-> (32'(svc_idx) < PINS));                           // R6
   AST_BAD_SIZE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_size != 4'd4 && acc_size != 4'd8)
         |=> (!svc_stb && resp_err));                               // R7
   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write && acc_addr[7:0] == OFS_WIN && sel_q == SEL_ID)
         |=> $stable(id_q));                                        // R3

endmodule

// File: tb/intr_route_regs_tb_top.sv
`timescale 1ns/1ps
module intr_route_regs_tb_top;

   localparam int PINS   = 24;
   localparam int ADDR_W = 12;
   localparam int IDX_W  = $clog2(PINS);
   localparam int NV     = 43;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [3:0]        acc_size = 4'd4;
   logic [63:0]       acc_wdata = '0;
   logic              resp_valid;
   logic              resp_err;
   logic [31:0]       resp_data;
   logic [PINS-1:0]   rirr_set = '0;
   logic [PINS-1:0]   pin_lvl = '0;
   logic [PINS-1:0]   pend;
   logic              svc_stb;
   logic [IDX_W-1:0]  svc_idx;
   logic [PINS*8-1:0] ent_vector;
   logic [PINS*3-1:0] ent_dlv_mode;
   logic [PINS-1:0]   ent_dst_mode;
   logic [PINS-1:0]   ent_polarity;
   logic [PINS-1:0]   ent_rirr;
   logic [PINS-1:0]   ent_level;
   logic [PINS-1:0]   ent_mask;
   logic [PINS*8-1:0] ent_dest;

   int nchk  = 0;
   int nfail = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   intr_route_regs #(.PINS(PINS), .ADDR_W(ADDR_W), .VERSION(8'h11)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_wdata(acc_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data),
      .rirr_set(rirr_set), .pin_lvl(pin_lvl), .pend(pend),
      .svc_stb(svc_stb), .svc_idx(svc_idx),
      .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
      .ent_dst_mode(ent_dst_mode), .ent_polarity(ent_polarity),
      .ent_rirr(ent_rirr), .ent_level(ent_level), .ent_mask(ent_mask),
      .ent_dest(ent_dest)
   );

   // {req[4], wr, addr[12], size[4], wdata[64], exp_data[32], exp_err}
   localparam logic [117:0] VECS [NV] = '{
      {4'd1,  1'b1, 12'h000, 4'd4, 64'h10,               32'h0,        1'b0}, // R1
      {4'd1,  1'b0, 12'h000, 4'd4, 64'h0,                32'h10,       1'b0}, // R1
      {4'd8,  1'b0, 12'h010, 4'd4, 64'h0,                32'h00010000, 1'b0}, // R8
      {4'd5,  1'b1, 12'h010, 4'd4, 64'hE031,             32'h0,        1'b0}, // R5
      {4'd5,  1'b0, 12'h010, 4'd4, 64'h0,                32'h0000A031, 1'b0}, // R5
      {4'd4,  1'b1, 12'h000, 4'd4, 64'h11,               32'h0,        1'b0}, // R4
      {4'd4,  1'b1, 12'h010, 4'd4, 64'hAB000000,         32'h0,        1'b0}, // R4
      {4'd4,  1'b0, 12'h010, 4'd4, 64'h0,                32'hAB000000, 1'b0}, // R4
      {4'd1,  1'b0, 12'h110, 4'd4, 64'h0,                32'hAB000000, 1'b0}, // R1
      {4'd4,  1'b1, 12'h000, 4'd4, 64'h10,               32'h0,        1'b0}, // R4
      {4'd4,  1'b0, 12'h010, 4'd4, 64'h0,                32'h0000A031, 1'b0}, // R4
      {4'd2,  1'b1, 12'h000, 4'd4, 64'h01,               32'h0,        1'b0}, // R2
      {4'd2,  1'b0, 12'h010, 4'd4, 64'h0,                32'h00170011, 1'b0}, // R2
      {4'd2,  1'b1, 12'h010, 4'd4, 64'hFFFFFFFF,         32'h0,        1'b0}, // R2
      {4'd2,  1'b0, 12'h010, 4'd4, 64'h0,                32'h00170011, 1'b0}, // R2
      {4'd7,  1'b0, 12'h010, 4'd2, 64'h0,                32'h00000011, 1'b0}, // R7
      {4'd3,  1'b1, 12'h000, 4'd4, 64'h00,               32'h0,        1'b0}, // R3
      {4'd3,  1'b1, 12'h010, 4'd4, 64'h05000000,         32'h0,        1'b0}, // R3
      {4'd3,  1'b0, 12'h010, 4'd4, 64'h0,                32'h05000000, 1'b0}, // R3
      {4'd3,  1'b1, 12'h000, 4'd4, 64'h02,               32'h0,        1'b0}, // R3
      {4'd3,  1'b0, 12'h010, 4'd4, 64'h0,                32'h05000000, 1'b0}, // R3
      {4'd3,  1'b1, 12'h010, 4'd4, 64'h09000000,         32'h0,        1'b0}, // R3
      {4'd3,  1'b0, 12'h010, 4'd4, 64'h0,                32'h05000000, 1'b0}, // R3
      {4'd7,  1'b1, 12'h000, 4'd2, 64'h55,               32'h0,        1'b1}, // R7
      {4'd7,  1'b0, 12'h000, 4'd4, 64'h0,                32'h02,       1'b0}, // R7
      {4'd7,  1'b1, 12'h000, 4'd8, 64'hDEAD000000000013, 32'h0,        1'b0}, // R7
      {4'd7,  1'b0, 12'h000, 4'd4, 64'h0,                32'h13,       1'b0}, // R7
      {4'd7,  1'b0, 12'h000, 4'd1, 64'h0,                32'h13,       1'b0}, // R7
      {4'd7,  1'b0, 12'h000, 4'd3, 64'h0,                32'h0,        1'b1}, // R7
      {4'd4,  1'b0, 12'h010, 4'd4, 64'h0,                32'h0,        1'b0}, // R4
      {4'd4,  1'b1, 12'h000, 4'd4, 64'h12,               32'h0,        1'b0}, // R4
      {4'd8,  1'b0, 12'h010, 4'd4, 64'h0,                32'h00010000, 1'b0}, // R8
      {4'd6,  1'b1, 12'h000, 4'd4, 64'h40,               32'h0,        1'b0}, // R6
      {4'd6,  1'b1, 12'h010, 4'd4, 64'h77,               32'h0,        1'b0}, // R6
      {4'd6,  1'b0, 12'h010, 4'd4, 64'h0,                32'h0,        1'b0}, // R6
      {4'd6,  1'b1, 12'h000, 4'd4, 64'h3F,               32'h0,        1'b0}, // R6
      {4'd6,  1'b1, 12'h010, 4'd4, 64'h5A000000,         32'h0,        1'b0}, // R6
      {4'd6,  1'b0, 12'h010, 4'd4, 64'h0,                32'h5A000000, 1'b0}, // R6
      {4'd1,  1'b1, 12'h020, 4'd4, 64'h99,               32'h0,        1'b0}, // R1
      {4'd1,  1'b0, 12'h020, 4'd4, 64'h0,                32'h0,        1'b0}, // R1
      {4'd1,  1'b0, 12'h000, 4'd4, 64'h0,                32'h3F,       1'b0}, // R1
      {4'd1,  1'b1, 12'h000, 4'd4, 64'h05,               32'h0,        1'b0}, // R1
      {4'd1,  1'b0, 12'h010, 4'd4, 64'h0,                32'h0,        1'b0}  // R1
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   // one access; returns at the negedge where the response is visible
   task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                         input logic [3:0] sz, input logic [63:0] wd);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=<50000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      check("R8 mask", 64'(ent_mask), 64'({PINS{1'b1}}));
      check("R8 vector", 64'(ent_vector[63:0]), 64'h0);
      check("R8 pend", 64'(pend), 64'h0);
      check("R8 strobe", 64'(svc_stb), 64'h0);
      check("R13 idle", 64'(resp_valid), 64'h0);

      for (int i = 0; i < NV; i++) begin
         access(VECS[i][113], VECS[i][112:101], VECS[i][100:97], VECS[i][96:33]);
         check($sformatf("R%0d vec%0d data", VECS[i][117:114], i),
               64'(resp_data), 64'(VECS[i][32:1]));
         check($sformatf("R%0d vec%0d err", VECS[i][117:114], i),
               64'({resp_valid, resp_err}), 64'({1'b1, VECS[i][0]}));
      end

      // R6: out-of-range write raises no strobe
      access(1'b1, 12'h000, 4'd4, 64'h40);
      access(1'b1, 12'h010, 4'd4, 64'h1234);
      check("R6 no strobe", 64'(svc_stb), 64'h0);

      // R9: strobe after table write to entry 3 low
      access(1'b1, 12'h000, 4'd4, 64'h16);
      access(1'b1, 12'h010, 4'd4, 64'h00008B42);
      check("R9 strobe", 64'({svc_stb, svc_idx}), 64'({1'b1, 5'd3}));
      @(negedge clk);
      check("R9 one cycle", 64'(svc_stb), 64'h0);

      // R11: field placement for entry 3
      access(1'b1, 12'h000, 4'd4, 64'h17);
      access(1'b1, 12'h010, 4'd4, 64'hC3000000);
      check("R11 vector", 64'(ent_vector[3*8 +: 8]), 64'h42);
      check("R11 dlv", 64'(ent_dlv_mode[3*3 +: 3]), 64'h3);
      check("R11 flags", 64'({ent_dst_mode[3], ent_polarity[3], ent_level[3], ent_mask[3]}),
            64'b1010);
      check("R11 dest", 64'(ent_dest[3*8 +: 8]), 64'hC3);

      // R10: service-side set of remote IRR
      @(negedge clk); rirr_set[3] = 1'b1;
      @(negedge clk); rirr_set[3] = 1'b0;
      check("R10 set", 64'(ent_rirr[3]), 64'h1);
      access(1'b1, 12'h000, 4'd4, 64'h16);
      access(1'b0, 12'h010, 4'd4, 64'h0);
      check("R10 readback", 64'(resp_data), 64'h0000CB42);
      // R5: high write keeps the flag, low write clears it
      access(1'b1, 12'h000, 4'd4, 64'h17);
      access(1'b1, 12'h010, 4'd4, 64'hC3000000);
      check("R5 high keeps", 64'(ent_rirr[3]), 64'h1);
      access(1'b1, 12'h000, 4'd4, 64'h16);
      access(1'b1, 12'h010, 4'd4, 64'h00008B42);
      check("R5 low clears", 64'(ent_rirr[3]), 64'h0);

      // R10: simultaneous set and low write, write wins
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h010; acc_size = 4'd4;
      acc_wdata = 64'h00008B42; rirr_set[3] = 1'b1;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; rirr_set[3] = 1'b0;
      check("R10 write wins", 64'(ent_rirr[3]), 64'h0);

      // R12: pending = level xor polarity (entry 0 polarity 1, entry 3 polarity 0)
      @(negedge clk); pin_lvl = '0;
      @(negedge clk);
      check("R12 idle", 64'({pend[3], pend[0]}), 64'b01);
      pin_lvl[3] = 1'b1; pin_lvl[0] = 1'b1;
      @(negedge clk);
      check("R12 driven", 64'({pend[3], pend[0]}), 64'b10);

      finish_run();
   end

endmodule